// File: doc/BRIEF.md
# CPU Bank-Extension Register Unit

This unit widens a 16-bit processor address into a 20-bit space made of sixteen 64 KB banks. It holds two 4-bit bank registers. The code bank applies to instruction fetches and to every ordinary load or store. The data-pointer bank applies only to bus cycles that the processor marks as special data transfers, using a per-cycle flag. The unit drives the 4-bit bank that goes with the current 16-bit address, in the same cycle.

Both registers appear at CPU addresses 0 (code bank) and 1 (data-pointer bank) whatever bank is current. A bus cycle to either of these addresses is handled inside the unit: the external memory select stays low and a read returns the register value. A write to the code bank changes the bank of the very next bus cycle. The program counter is not involved, so execution continues at the same 16-bit address in the new bank. After reset both registers hold 15, the highest bank.

Top module: `bankx_unit`

## Requirements
- R1: After reset both bank registers hold 4'hF, so `bank_out` is 4'hF whether `ind_xfer` is 0 or 1.
- R2: When `ind_xfer` is 0, `bank_out` equals the code-bank register.
- R3: When `ind_xfer` is 1, `bank_out` equals the data-pointer-bank register.
- R4: A write (`cpu_wr`=1) to address 16'h0000 loads `cpu_wdata[3:0]` into the code bank, and `bank_out` shows the new value from the following cycle on.
- R5: A write to address 16'h0001 loads `cpu_wdata[3:0]` into the data-pointer bank only; the code bank is unchanged.
- R6: A read (`cpu_rd`=1) at address 16'h0000 or 16'h0001 returns the register value in `reg_rdata[3:0]` with bits 7:4 at 0; written upper bits are discarded.
- R7: `mem_cs` is 1 for a read or write at any address other than 0 and 1, and 0 for register accesses and idle cycles.
- R8: The register addresses decode the same whichever bank is selected at the time.
- R9: Writes to addresses other than 0 and 1 (for example 16'h0002 or 16'h0100) leave both registers unchanged.
- R10: `bank_out` follows a change of `ind_xfer` in the same cycle, with no clock edge in between.
- R11: `reg_rdata` is 0 in any cycle that is not a register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the bus cycle |
| cpu_rd | input | 1 | Read cycle |
| cpu_wr | input | 1 | Write cycle |
| cpu_wdata | input | 8 | Write data |
| ind_xfer | input | 1 | Current cycle is a special data transfer |
| bank_out | output | 4 | Bank for the current bus cycle |
| mem_cs | output | 1 | External memory select |
| reg_rdata | output | 8 | Register read data, zero-extended |

## Verification
On every cycle the assertions check that a register access never raises the memory select, that a code-bank write is the value seen one cycle later, that the data-pointer bank holds when not written, that decoded writes only come from addresses 0 and 1, and that read data carries no upper bits outside register reads. Only the bench scenarios show the reset value of 15, the one-cycle switch of the output bank after a write, and the choice between the two banks as the transfer flag toggles. They also show that the registers still answer at addresses 0 and 1 after the current bank has moved away from 15.

// File: rtl/bankx_pkg.sv
package bankx_pkg;
    localparam int BANKX_BANK_W = 4;
    localparam int BANKX_ADDR_W = 16;
    localparam int BANKX_DATA_W = 8;

    typedef enum logic {
        REG_CODE = 1'b0,
        REG_DPTR = 1'b1
    } bankx_reg_e;
endpackage

// File: rtl/bankx_dec.sv
module bankx_dec
    import bankx_pkg::*;
#(
    parameter int ADDR_W = BANKX_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              reg_hit,
    output logic              reg_rd,
    output bankx_reg_e        reg_sel,
    output logic              code_we,
    output logic              dptr_we,
    output logic              mem_cs
);
    logic low_pair;

    always_comb begin
        low_pair = (addr[ADDR_W-1:1] == '0);
        reg_hit  = (rd || wr) && low_pair;
        reg_rd   = rd && low_pair;
        reg_sel  = bankx_reg_e'(addr[0]);
        code_we  = wr && low_pair && (reg_sel == REG_CODE);
        dptr_we  = wr && low_pair && (reg_sel == REG_DPTR);
        mem_cs   = (rd || wr) && !low_pair;
    end

    // R9
    far_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(1)) |-> (!code_we && !dptr_we));

    // R7
    cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> !mem_cs);
endmodule

// File: rtl/bankx_regs.sv
module bankx_regs
    import bankx_pkg::*;
#(
    parameter int                BANK_W     = BANKX_BANK_W,
    parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_we,
    input  logic              dptr_we,
    input  logic [BANK_W-1:0] wbank,
    output logic [BANK_W-1:0] code_q,
    output logic [BANK_W-1:0] dptr_q
);
    typedef struct packed {
        logic [BANK_W-1:0] code;
        logic [BANK_W-1:0] dptr;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (code_we) st_d.code = wbank;
        if (dptr_we) st_d.dptr = wbank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= RESET_BANK;
            st_q.dptr <= RESET_BANK;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q = st_q.code;
    assign dptr_q = st_q.dptr;

    // R4
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_we |=> (code_q == $past(wbank)));

    // R5
    dptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dptr_we |=> (dptr_q == $past(dptr_q)));
endmodule

// File: rtl/bankx_sel.sv
module bankx_sel
    import bankx_pkg::*;
#(
    parameter int BANK_W = BANKX_BANK_W,
    parameter int DATA_W = BANKX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] code_q,
    input  logic [BANK_W-1:0] dptr_q,
    input  logic              ind_xfer,
    input  logic              reg_rd,
    input  bankx_reg_e        reg_sel,
    output logic [BANK_W-1:0] bank_out,
    output logic [DATA_W-1:0] rdata
);
    logic [BANK_W-1:0] rd_bank;

    always_comb begin
        bank_out = ind_xfer ? dptr_q : code_q;
        rd_bank  = (reg_sel == REG_DPTR) ? dptr_q : code_q;
        if (!reg_rd) rd_bank = '0;
    end

    generate
        if (DATA_W > BANK_W) begin : g_pad
            assign rdata = {{(DATA_W-BANK_W){1'b0}}, rd_bank};
        end else begin : g_trunc
            assign rdata = rd_bank[DATA_W-1:0];
        end
    endgenerate

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (rdata == '0));

    // R6
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata >> BANK_W) == '0);
endmodule

// File: rtl/bankx_unit.sv
module bankx_unit
    import bankx_pkg::*;
#(
    parameter int                ADDR_W     = BANKX_ADDR_W,
    parameter int                DATA_W     = BANKX_DATA_W,
    parameter int                BANK_W     = BANKX_BANK_W,
    parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ind_xfer,
    output logic [BANK_W-1:0] bank_out,
    output logic              mem_cs,
    output logic [DATA_W-1:0] reg_rdata
);
    logic              reg_hit, reg_rd, code_we, dptr_we;
    bankx_reg_e        reg_sel;
    logic [BANK_W-1:0] code_q, dptr_q;

    bankx_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
        .reg_hit(reg_hit), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .code_we(code_we), .dptr_we(dptr_we), .mem_cs(mem_cs)
    );

    bankx_regs #(.BANK_W(BANK_W), .RESET_BANK(RESET_BANK)) u_regs (
        .clk(clk), .rst_n(rst_n), .code_we(code_we), .dptr_we(dptr_we),
        .wbank(cpu_wdata[BANK_W-1:0]), .code_q(code_q), .dptr_q(dptr_q)
    );

    bankx_sel #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .code_q(code_q), .dptr_q(dptr_q),
        .ind_xfer(ind_xfer), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .bank_out(bank_out), .rdata(reg_rdata)
    );

    // R3
    dptr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_xfer && !$past(dptr_we)) |-> (bank_out == $past(bank_out) || !$past(ind_xfer)));

    // R7
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (!mem_cs && !reg_hit));
endmodule

// File: tb/test_bankx_unit.sv
`timescale 1ns/1ps
module test_bankx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, ind_xfer = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  bank_out;
    logic        mem_cs;
    logic [7:0]  reg_rdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bankx_unit i_bankx_unit (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .ind_xfer(ind_xfer),
        .bank_out(bank_out), .mem_cs(mem_cs), .reg_rdata(reg_rdata)
    );

    // {wr, rd, flag, addr, wdata, exp_bank, exp_cs, exp_rdata, req}
    localparam int NV = 18;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,16'h1234,8'h00,4'hF,1'b1,8'h00,4'd2},  // R2, R11
        {1'b0,1'b1,1'b1,16'h1234,8'h00,4'hF,1'b1,8'h00,4'd3},  // R3
        {1'b1,1'b0,1'b0,16'h0000,8'hA3,4'hF,1'b0,8'h00,4'd4},  // R4 write code=3
        {1'b0,1'b1,1'b0,16'h4000,8'h00,4'h3,1'b1,8'h00,4'd4},  // R4 next cycle
        {1'b0,1'b1,1'b1,16'h4000,8'h00,4'hF,1'b1,8'h00,4'd5},  // R5 dptr still F
        {1'b1,1'b0,1'b0,16'h0001,8'h5C,4'h3,1'b0,8'h00,4'd5},  // R5 write dptr=C
        {1'b0,1'b1,1'b1,16'h8000,8'h00,4'hC,1'b1,8'h00,4'd3},  // R3
        {1'b0,1'b1,1'b0,16'h8000,8'h00,4'h3,1'b1,8'h00,4'd5},  // R5 code kept
        {1'b0,1'b1,1'b0,16'h0000,8'h00,4'h3,1'b0,8'h03,4'd8},  // R8, R6
        {1'b0,1'b1,1'b0,16'h0001,8'h00,4'h3,1'b0,8'h0C,4'd6},  // R6
        {1'b1,1'b0,1'b0,16'h0002,8'h77,4'h3,1'b1,8'h00,4'd9},  // R9
        {1'b1,1'b0,1'b0,16'h0100,8'h11,4'h3,1'b1,8'h00,4'd9},  // R9
        {1'b0,1'b1,1'b0,16'h0000,8'h00,4'h3,1'b0,8'h03,4'd9},  // R9 code intact
        {1'b0,1'b1,1'b0,16'h0001,8'h00,4'h3,1'b0,8'h0C,4'd9},  // R9 dptr intact
        {1'b0,1'b0,1'b1,16'h0000,8'h00,4'hC,1'b0,8'h00,4'd7},  // R7 idle, R10
        {1'b0,1'b0,1'b0,16'h0000,8'h00,4'h3,1'b0,8'h00,4'd10}, // R10
        {1'b1,1'b0,1'b1,16'h0000,8'hFF,4'hC,1'b0,8'h00,4'd8},  // R8 write code=F
        {1'b0,1'b1,1'b0,16'h0000,8'h00,4'hF,1'b0,8'h0F,4'd6}   // R6
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic fl, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; ind_xfer = fl; cpu_addr = a; cpu_wdata = d;
        #1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, both flag values
        drive(0, 0, 0, 16'h0000, 8'h00);
        chk("R1", "bank code", {4'h0, bank_out}, 8'h0F);
        drive(0, 0, 1, 16'h0000, 8'h00);
        chk("R1", "bank dptr", {4'h0, bank_out}, 8'h0F);
        chk("R7", "idle cs", {7'h0, mem_cs}, 8'h00);
        drive(0, 1, 0, 16'h0001, 8'h00);
        chk("R1", "dptr read", reg_rdata, 8'h0F);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[3:0]);
            drive(v[43], v[42], v[41], v[40:25], v[24:17]);
            chk(tag, $sformatf("vec%0d bank", i), {4'h0, bank_out}, {4'h0, v[16:13]});
            chk(tag, $sformatf("vec%0d cs", i), {7'h0, mem_cs}, {7'h0, v[12]});
            chk(tag, $sformatf("vec%0d rdata", i), reg_rdata, v[11:4]);
        end

        // R1 reset mid-run restores bank 15
        drive(1, 0, 0, 16'h0000, 8'h05);
        drive(1, 0, 0, 16'h0001, 8'h06);
        drive(0, 0, 0, 16'h0000, 8'h00);
        chk("R4", "code before reset", {4'h0, bank_out}, 8'h05);
        rst_n = 1'b0;
        #1;
        chk("R1", "code after reset", {4'h0, bank_out}, 8'h0F);
        ind_xfer = 1'b1;
        #1;
        chk("R1", "dptr after reset", {4'h0, bank_out}, 8'h0F);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 decode with code bank moved to 0
        drive(1, 0, 0, 16'h0000, 8'h00);
        drive(0, 1, 0, 16'h0001, 8'h00);
        chk("R8", "dptr read in bank 0", reg_rdata, 8'h0F);
        chk("R8", "bank in bank 0", {4'h0, bank_out}, 8'h00);
        drive(0, 0, 0, 16'h0000, 8'h00);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule